// File: doc/BRIEF.md
# Automatic Capture Level Control with Noise Gate

This block closes a digital gain loop around one capture channel of a stereo recording path. Each time a converter sample arrives, it measures the magnitude of the selected channel on a logarithmic scale with 1.5 dB resolution and keeps the peak of the current measuring window. Once a rate counter expires, it moves a 6-bit amplifier gain code by one step toward a programmable target level. The counter is scaled by a separate attack code when the signal is too loud and by a separate decay code when it is too quiet. The gain never rises above a programmable ceiling and never falls below code 0.

A noise gate sits inside the same loop. When the gate is enabled and a sample measures below the gate threshold, the gain and the rate counter are frozen. Depending on the gate type, a mute flag may also be raised for the downstream path. When the loop is disabled, the gain code simply follows a manually programmed gain value, so the loop always starts from the software setting.

Top module: `alc_gain_loop`

## Requirements
- R1: After reset the gain code is 23 (0 dB) and the mute flag is low.
- R2: When the channel select is 00 or 11, the loop is off: the gain code equals the manual gain one clock later, samples have no effect on it, and the mute flag is low.
- R3: While the loop is on, the gain code never exceeds the ceiling 15 + 4*m, where m is the 3-bit ceiling code. A gain above the ceiling is pulled down to the ceiling on the next clock.
- R4: When the window peak is above the target, the gain drops by one code on the strobe that completes 8 << min(a,10) strobes, where a is the attack code. The gain never goes below 0.
- R5: When the window peak is below the target, the gain rises by one code on the strobe that completes 32 << min(d,10) strobes, where d is the decay code. The rise is limited by the ceiling.
- R6: A sample's level is 4*p + f. Here p is the bit position of the leading one of |x| (saturated to 2^(W-1)-1), f is the two bits just below that leading one, and the level is 0 for x = 0. The target level is 4*(W-2)+3-19+t, where t is the 4-bit target code. A window peak equal to the target restarts the window without changing the gain.
- R7: Select 10 measures the left sample only. Select 01 measures the right sample only.
- R8: With the gate enabled, a sample whose level is below 4*(W-2)+3-51+g is gated, where g is the 5-bit threshold. A gated sample changes neither the gain nor the rate counter. With gate type 01, the mute flag is raised on that strobe. The flag is cleared by the next strobe that is not gated, and it is also cleared on any clock where the gate is disabled or the type is not 01.
- R9: Gate types 00, 10 and 11 freeze the loop on gated samples but never raise the mute flag.
- R10: While the loop is on and the ceiling is unchanged, the gain code changes only on the clock edge where a sample strobe is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample pair |
| smp_left | input | SMP_W | Left signed sample |
| smp_right | input | SMP_W | Right signed sample |
| chan_sel | input | 2 | 00 off, 01 right, 10 left, 11 off |
| target_code | input | 4 | Target level, 1.5 dB per code |
| max_gain_code | input | 3 | Gain ceiling, 6 dB per code |
| attack_code | input | 4 | Attack rate exponent, clamped to 10 |
| decay_code | input | 4 | Decay rate exponent, clamped to 10 |
| gate_en | input | 1 | Noise gate enable |
| gate_thresh | input | 5 | Gate threshold, 1.5 dB per code |
| gate_type | input | 2 | 01 mutes, other values hold only |
| manual_gain | input | 6 | Gain code used while the loop is off |
| gain_code | output | 6 | Amplifier gain code |
| gate_mute | output | 1 | Mute request from the noise gate |

## Verification
Every result is registered once. A strobe presented in one cycle therefore shows its effect on the gain code and the mute flag right after the next rising edge, and turning the loop off or lowering the ceiling is also visible one edge later. The bench drives inputs and samples outputs on falling edges. Each stimulus takes exactly one full cycle, so every check falls on the first falling edge after the edge that commits the result. Rate tests count strobes to one short of the expected step, check that the gain is unchanged, then apply one more strobe and check the step.

// File: rtl/alc_pkg.sv
package alc_pkg;
    localparam int GAIN_W     = 6;
    localparam int GAIN_UNITY = 23;   // 0 dB
    localparam int CEIL_BASE  = 15;   // -12 dB
    localparam int CEIL_STEP  = 4;    // 6 dB in 1.5 dB codes
    localparam int TGT_BELOW  = 19;   // target code 0 relative to full scale
    localparam int GATE_BELOW = 51;   // gate code 0 relative to full scale
    localparam int RATE_EXP_MAX = 10;

    typedef enum logic [1:0] {
        SEL_OFF   = 2'b00,
        SEL_RIGHT = 2'b01,
        SEL_LEFT  = 2'b10,
        SEL_SPARE = 2'b11
    } chan_sel_e;
endpackage

// File: rtl/alc_level_meter.sv
module alc_level_meter #(
    parameter int SMP_W = 16,
    localparam int LVL_W = $clog2(4 * SMP_W)
) (
    input  logic signed [SMP_W-1:0] smp,
    output logic [LVL_W-1:0]        lvl
);
    logic [SMP_W-1:0] mag;
    logic [SMP_W-1:0] shifted;
    logic [1:0]       frac;
    int               lead;

    always_comb begin
        mag = smp[SMP_W-1] ? (~smp + 1'b1) : smp;
        if (mag[SMP_W-1]) mag = {1'b0, {(SMP_W-1){1'b1}}};
        lead = 0;
        for (int i = 0; i < SMP_W - 1; i++) begin
            if (mag[i]) lead = i;
        end
        shifted = '0;
        if (lead >= 2) begin
            shifted = mag >> (lead - 2);
            frac    = shifted[1:0];
        end else if (lead == 1) begin
            frac = {mag[0], 1'b0};
        end else begin
            frac = 2'b00;
        end
        if (mag == '0) lvl = '0;
        else           lvl = LVL_W'(4 * lead + int'(frac));
    end
endmodule

// File: rtl/alc_rate_limit.sv
module alc_rate_limit
    import alc_pkg::*;
#(
    parameter int BASE  = 8,
    parameter int CNT_W = 16
) (
    input  logic [3:0]       code,
    output logic [CNT_W-1:0] period
);
    logic [3:0] eff;

    always_comb begin
        eff    = (int'(code) > RATE_EXP_MAX) ? 4'(RATE_EXP_MAX) : code;
        period = CNT_W'(BASE) << eff;
    end
endmodule

// File: rtl/alc_gain_loop.sv
module alc_gain_loop
    import alc_pkg::*;
#(
    parameter int SMP_W    = 16,
    parameter int ATK_BASE = 8,
    parameter int DCY_BASE = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    smp_valid,
    input  logic signed [SMP_W-1:0] smp_left,
    input  logic signed [SMP_W-1:0] smp_right,
    input  logic [1:0]              chan_sel,
    input  logic [3:0]              target_code,
    input  logic [2:0]              max_gain_code,
    input  logic [3:0]              attack_code,
    input  logic [3:0]              decay_code,
    input  logic                    gate_en,
    input  logic [4:0]              gate_thresh,
    input  logic [1:0]              gate_type,
    input  logic [5:0]              manual_gain,
    output logic [5:0]              gain_code,
    output logic                    gate_mute
);
    localparam int LVL_W  = $clog2(4 * SMP_W);
    localparam int FS_LVL = 4 * (SMP_W - 2) + 3;
    localparam int CNT_W  = $clog2(DCY_BASE) + RATE_EXP_MAX + 1;
    localparam int N_CH   = 2;

    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        logic [CNT_W-1:0]  cnt;
        logic [LVL_W-1:0]  peak;
        logic              mute;
    } loop_state_t;

    loop_state_t state_d, state_q;

    logic signed [SMP_W-1:0] smp_ch [N_CH];
    logic [LVL_W-1:0]        lvl_ch [N_CH];
    logic [CNT_W-1:0]        atk_period, dcy_period;
    logic                    alc_on;
    logic [GAIN_W-1:0]       ceil_code;

    assign smp_ch[0] = smp_left;
    assign smp_ch[1] = smp_right;

    for (genvar g = 0; g < N_CH; g++) begin : g_meter
        alc_level_meter #(.SMP_W(SMP_W)) u_meter (
            .smp (smp_ch[g]),
            .lvl (lvl_ch[g])
        );
    end

    alc_rate_limit #(.BASE(ATK_BASE), .CNT_W(CNT_W)) u_atk_rate (
        .code   (attack_code),
        .period (atk_period)
    );
    alc_rate_limit #(.BASE(DCY_BASE), .CNT_W(CNT_W)) u_dcy_rate (
        .code   (decay_code),
        .period (dcy_period)
    );

    assign alc_on    = (chan_sel == SEL_LEFT) || (chan_sel == SEL_RIGHT);
    assign ceil_code = GAIN_W'(CEIL_BASE + CEIL_STEP * int'(max_gain_code));

    always_comb begin
        int               tgt_lvl;
        int               gate_lvl;
        int               next_cnt;
        logic [LVL_W-1:0] cur_lvl;
        logic [LVL_W-1:0] pk;
        logic             gated;

        tgt_lvl  = FS_LVL - TGT_BELOW + int'(target_code);
        gate_lvl = FS_LVL - GATE_BELOW + int'(gate_thresh);
        cur_lvl  = (chan_sel == SEL_LEFT) ? lvl_ch[0] : lvl_ch[1];
        pk       = (cur_lvl > state_q.peak) ? cur_lvl : state_q.peak;
        gated    = gate_en && (int'(cur_lvl) < gate_lvl);
        next_cnt = int'(state_q.cnt) + 1;
        state_d  = state_q;

        if (!alc_on) begin
            state_d.gain = manual_gain;
            state_d.cnt  = '0;
            state_d.peak = '0;
            state_d.mute = 1'b0;
        end else begin
            state_d.mute = state_q.mute && gate_en && (gate_type == 2'b01);
            if (smp_valid) begin
                if (gated) begin
                    state_d.mute = (gate_type == 2'b01);
                end else begin
                    state_d.mute = 1'b0;
                    if (int'(pk) > tgt_lvl) begin
                        if (next_cnt >= int'(atk_period)) begin
                            if (state_q.gain != '0) state_d.gain = state_q.gain - 1'b1;
                            state_d.cnt  = '0;
                            state_d.peak = '0;
                        end else begin
                            state_d.cnt  = CNT_W'(next_cnt);
                            state_d.peak = pk;
                        end
                    end else if (int'(pk) < tgt_lvl) begin
                        if (next_cnt >= int'(dcy_period)) begin
                            if (state_q.gain < ceil_code) state_d.gain = state_q.gain + 1'b1;
                            state_d.cnt  = '0;
                            state_d.peak = '0;
                        end else begin
                            state_d.cnt  = CNT_W'(next_cnt);
                            state_d.peak = pk;
                        end
                    end else begin
                        state_d.cnt  = '0;
                        state_d.peak = '0;
                    end
                end
            end
            if (state_d.gain > ceil_code) state_d.gain = ceil_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.gain <= GAIN_W'(GAIN_UNITY);
            state_q.cnt  <= '0;
            state_q.peak <= '0;
            state_q.mute <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign gain_code = state_q.gain;
    assign gate_mute = state_q.mute;

    // R3: the ceiling holds once the loop has been on for a clock
    p_gain_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alc_on) && $stable(max_gain_code)) |-> (gain_code <= ceil_code));

    // R4, R5: one code per step at most
    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alc_on, 2) && $past(alc_on) && $stable(max_gain_code)
         && ($past(max_gain_code, 2) == $past(max_gain_code)))
        |-> ((gain_code == $past(gain_code))
             || (gain_code == $past(gain_code) + 6'd1)
             || (gain_code + 6'd1 == $past(gain_code))));

    // R10: no movement without a strobe
    p_strobe_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(alc_on, 2) && $past(alc_on) && !$past(smp_valid)
         && ($past(max_gain_code, 2) == $past(max_gain_code)))
        |-> $stable(gain_code));

    // R8: mute only from an enabled gate of the muting type
    p_mute_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        gate_mute |-> ($past(alc_on) && $past(gate_en) && ($past(gate_type) == 2'b01)));

    // R2: loop off means no mute and manual gain
    p_off_manual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(alc_on) |-> (!gate_mute && (gain_code == $past(manual_gain))));
endmodule

// File: tb/tb_alc_gain_loop.sv
module tb_alc_gain_loop;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               smp_valid = 1'b0;
    logic signed [15:0] smp_left = '0;
    logic signed [15:0] smp_right = '0;
    logic [1:0]         chan_sel = 2'b00;
    logic [3:0]         target_code = 4'd11;
    logic [2:0]         max_gain_code = 3'd7;
    logic [3:0]         attack_code = 4'd0;
    logic [3:0]         decay_code = 4'd4;
    logic               gate_en = 1'b0;
    logic [4:0]         gate_thresh = 5'd31;
    logic [1:0]         gate_type = 2'b00;
    logic [5:0]         manual_gain = 6'd23;
    logic [5:0]         gain_code;
    logic               gate_mute;

    int n_vec = 0;
    int n_bad = 0;

    localparam logic signed [15:0] LOUD   = 16'sd16384;  // level 56
    localparam logic signed [15:0] MAXNEG = -16'sd32768; // level 59
    localparam logic signed [15:0] ONTGT  = 16'sd7168;   // level 51
    localparam logic signed [15:0] HOT    = 16'sd20000;  // level 56
    localparam logic signed [15:0] SOFT   = 16'sd256;    // level 32
    localparam logic signed [15:0] MID    = 16'sd1024;   // level 40
    localparam logic signed [15:0] HUSH   = 16'sd64;     // level 24

    always #10ns clk = ~clk;

    alc_gain_loop dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .chan_sel(chan_sel),
        .target_code(target_code), .max_gain_code(max_gain_code),
        .attack_code(attack_code), .decay_code(decay_code),
        .gate_en(gate_en), .gate_thresh(gate_thresh), .gate_type(gate_type),
        .manual_gain(manual_gain), .gain_code(gain_code), .gate_mute(gate_mute)
    );

    task automatic check(input string tag, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic strobe(input logic signed [15:0] l, input logic signed [15:0] r);
        @(negedge clk);
        smp_left  = l;
        smp_right = r;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic load_gain(input logic [5:0] v, input logic [1:0] sel);
        @(negedge clk);
        chan_sel    = 2'b00;
        manual_gain = v;
        @(negedge clk);
        chan_sel = sel;
    endtask

    task automatic t_reset;
        check("R1 reset gain", gain_code, 23);
        check("R1 reset mute", gate_mute, 0);
    endtask

    task automatic t_disabled;
        load_gain(6'd10, 2'b00);
        idle(1);
        check("R2 off follows manual", gain_code, 10);
        for (int i = 0; i < 20; i++) strobe(LOUD, LOUD);
        check("R2 off ignores samples", gain_code, 10);
        load_gain(6'd50, 2'b11);
        for (int i = 0; i < 20; i++) strobe(HUSH, HUSH);
        check("R2 select 11 is off", gain_code, 50);
        check("R2 off mute low", gate_mute, 0);
    endtask

    task automatic t_attack;
        attack_code = 4'd0;
        load_gain(6'd30, 2'b10);
        for (int i = 0; i < 7; i++) strobe((i % 2) ? MAXNEG : LOUD, 16'sd0);
        check("R4 attack before period", gain_code, 30);
        idle(20);
        check("R10 no change between strobes", gain_code, 30);
        strobe(LOUD, 16'sd0);
        check("R4 attack step", gain_code, 29);
        for (int i = 0; i < 7; i++) strobe(-LOUD, 16'sd0);
        check("R4 second window held", gain_code, 29);
        strobe(-LOUD, 16'sd0);
        check("R4 second step", gain_code, 28);
    endtask

    task automatic t_channel;
        load_gain(6'd30, 2'b01);
        for (int i = 0; i < 20; i++) strobe(MAXNEG, ONTGT);
        check("R6 R7 on-target right, loud left ignored", gain_code, 30);
        for (int i = 0; i < 7; i++) strobe(ONTGT, HOT);
        check("R7 right loud before period", gain_code, 30);
        strobe(ONTGT, HOT);
        check("R7 right channel attack", gain_code, 29);
    endtask

    task automatic t_decay;
        decay_code = 4'd0;
        load_gain(6'd20, 2'b10);
        for (int i = 0; i < 31; i++) strobe(SOFT, LOUD);
        check("R5 decay before period", gain_code, 20);
        strobe(-SOFT, LOUD);
        check("R5 decay step", gain_code, 21);
    endtask

    task automatic t_clamp;
        @(negedge clk);
        max_gain_code = 3'd0;
        @(negedge clk);
        check("R3 clamp to ceiling", gain_code, 15);
        for (int i = 0; i < 70; i++) strobe(SOFT, SOFT);
        check("R3 decay stops at ceiling", gain_code, 15);
        @(negedge clk);
        max_gain_code = 3'd7;
    endtask

    task automatic t_floor;
        attack_code = 4'd0;
        load_gain(6'd1, 2'b10);
        for (int i = 0; i < 8; i++) strobe(LOUD, 16'sd0);
        check("R4 down to zero", gain_code, 0);
        for (int i = 0; i < 16; i++) strobe(LOUD, 16'sd0);
        check("R4 floor at zero", gain_code, 0);
    endtask

    task automatic t_slow_attack;
        attack_code = 4'd2;
        load_gain(6'd30, 2'b10);
        for (int i = 0; i < 31; i++) strobe(LOUD, 16'sd0);
        check("R4 code 2 before period", gain_code, 30);
        strobe(LOUD, 16'sd0);
        check("R4 code 2 step", gain_code, 29);
        attack_code = 4'd15;
        load_gain(6'd30, 2'b10);
        for (int i = 0; i < 8191; i++) strobe(LOUD, 16'sd0);
        check("R4 clamped code before period", gain_code, 30);
        strobe(LOUD, 16'sd0);
        check("R4 clamped code step", gain_code, 29);
        attack_code = 4'd0;
    endtask

    task automatic t_gate_hold;
        decay_code  = 4'd0;
        gate_en     = 1'b1;
        gate_thresh = 5'd31;
        gate_type   = 2'b00;
        load_gain(6'd20, 2'b10);
        for (int i = 0; i < 40; i++) strobe(HUSH, 16'sd0);
        check("R8 gated gain frozen", gain_code, 20);
        check("R9 hold type no mute", gate_mute, 0);
        for (int i = 0; i < 31; i++) strobe(MID, 16'sd0);
        check("R8 counter frozen while gated", gain_code, 20);
        strobe(MID, 16'sd0);
        check("R8 decay after gate opens", gain_code, 21);
    endtask

    task automatic t_gate_mute;
        gate_en   = 1'b1;
        gate_type = 2'b01;
        load_gain(6'd20, 2'b10);
        strobe(HUSH, 16'sd0);
        check("R8 mute raised", gate_mute, 1);
        idle(5);
        check("R8 mute held between strobes", gate_mute, 1);
        check("R8 muted gain unchanged", gain_code, 20);
        strobe(MID, 16'sd0);
        check("R8 mute cleared by open strobe", gate_mute, 0);
        strobe(HUSH, 16'sd0);
        check("R8 mute raised again", gate_mute, 1);
        @(negedge clk);
        chan_sel = 2'b00;
        @(negedge clk);
        check("R2 mute cleared when off", gate_mute, 0);
        gate_type = 2'b11;
        load_gain(6'd20, 2'b10);
        strobe(HUSH, 16'sd0);
        check("R9 type 11 no mute", gate_mute, 0);
        gate_type = 2'b10;
        strobe(HUSH, 16'sd0);
        check("R9 type 10 no mute", gate_mute, 0);
        gate_en = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(2);
        t_disabled();
        t_attack();
        t_channel();
        t_decay();
        t_clamp();
        t_floor();
        t_slow_attack();
        t_gate_hold();
        t_gate_mute();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule